// File: doc/BRIEF.md
# Synthesiser Control Register Interface over I2C

This block is the two-wire slave that programs a frequency synthesiser. It samples the clock and data lines of an I2C bus on a fast system clock and finds START and STOP conditions and bit edges. It answers one of four device addresses, chosen by a 2-bit select input. In write frames it decodes the data bytes into a 17-bit divide ratio, a prescaler enable, a reference-divider code, charge-pump current bits, reference-output enable and select bits, four port drive bits and a test-mode code. In read frames it returns one status byte, which carries the power-on flag, the lock flag and a 3-bit converter code.

The first bit of each data byte sets its role. A leading 0 marks a high-frequency byte, which is always followed by the low-frequency byte. A leading 1 marks a control byte, which is always followed by the port byte. The pairs may come in either order and may repeat without a new address.

A new divide ratio does not reach the output piece by piece. It becomes active only when all 17 frequency bits have been received since the last update, or when a STOP ends the frame. Tuning software can therefore rewrite the ratio without passing through intermediate values.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The slave acknowledges (SDA pulled low on the ninth clock) an address byte equal to binary 11000, addr_sel[1], addr_sel[0], then R/W, where R/W = 1 means read. It also acknowledges every data byte of a write frame. Any other address gets no acknowledge, and the slave ignores the rest of that frame.
- R2: In a write frame, a data byte that opens a pair is decoded by its bit 7.
  - If bit 7 = 0, bits 6..0 go to ratio bits 14..8, and the next byte gives ratio bits 7..0.
  - If bit 7 = 1, bits 6..5 go to ratio bits 16..15, bit 4 to presc_en and bits 3..0 to ref_code. The next byte is the port byte.
  - Pairs repeat until STOP, in either order.
- R3: div_ratio changes in only two cases: all three frequency parts (the high byte, the low byte and the two bits from the control byte) have arrived since the last update, or a STOP ends the frame (R4). It changes in the cycle after the byte that completes the set, and before any STOP. Repeating only the high and low frequency bytes leaves it unchanged.
- R4: A STOP after one or more received frequency parts makes the new parts active, merged with the parts held from earlier frames.
- R5: A STOP inside a byte discards the partial byte. Data from earlier complete bytes of the same frame is kept and committed.
- R6: The port byte sets cp_cur from bits 7..6, refout_en from bit 5, refout_sel from bit 4 and port_drv from bits 3..0. Control-byte and port-byte fields take effect as soon as their byte is received.
- R7: A port byte with bit 5 = 0 and bit 4 = 1 selects test mode. test_active goes to 1, test_code takes bits 2..0, port_drv[3] takes bit 3, and port_drv[2:0] keep their earlier values.
- R8: The read status byte is {por_flag, lock_in, 000, adc_code}, MSB first. The power-on flag clears when a STOP ends a frame in which a status byte was sent.
- R9: When the master does not acknowledge a status byte, the slave releases SDA and sends no further bits until the next START.
- R10: rst or por_event sets the following state: div_ratio = 0, presc_en = 0, ref_code = 0, cp_cur = 0, refout_en = 1, refout_sel = 1, test_active = 0, port_drv = 0 and port_hiz = 1. It also sets the power-on flag. port_hiz stays 1 until the next port byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_sel | input | 2 | Selects one of four device addresses |
| lock_in | input | 1 | Phase-lock flag reported in the status byte |
| adc_code | input | 3 | Converter code reported in the status byte |
| por_event | input | 1 | Power-on event; clears programmed state |
| div_ratio | output | 17 | Active divide ratio |
| presc_en | output | 1 | Prescaler enable |
| ref_code | output | 4 | Reference-divider code |
| cp_cur | output | 2 | Charge-pump current select |
| refout_en | output | 1 | Reference/comparison output enable |
| refout_sel | output | 1 | Reference/comparison select, or test-mode request |
| port_drv | output | 4 | Port sink enables |
| port_hiz | output | 1 | 1 while ports are released after power-on |
| test_active | output | 1 | Test mode selected |
| test_code | output | 3 | Test-mode code, 0 when not active |

## Verification
The bench writes full frames in both pair orders, high/low first and control/port first. It checks the ratio before STOP, which separates the commit that happens once all 17 bits are in from the commit made by STOP. Frames that repeat only the frequency pair, that send one frequency byte then STOP, or that STOP in the middle of a byte separate merged partial updates from discarded ones. Read frames with acknowledge, without acknowledge and with extra clocks show the status layout, the clearing of the power-on flag and the release of SDA. A wrong address, a test-mode port byte and a power-on event cover the remaining paths.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

    localparam int DIV_W  = 17;
    localparam int BYTE_W = 8;
    localparam logic [4:0] DEV_ID = 5'b11000;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_RX,
        BS_ACK,
        BS_TX,
        BS_RACK
    } bus_state_e;

    typedef enum logic [1:0] {
        ROLE_LEAD,
        ROLE_LOW,
        ROLE_CTRL
    } byte_role_e;

    typedef struct packed {
        logic       pe;
        logic [3:0] ref_code;
        logic [1:0] cp;
        logic       re;
        logic       rts;
        logic [3:0] port;
        logic [2:0] tst;
    } ctl_regs_t;

    localparam ctl_regs_t CTL_RESET = '{
        pe: 1'b0, ref_code: 4'h0, cp: 2'b00,
        re: 1'b1, rts: 1'b1, port: 4'h0, tst: 3'b000
    };

    function automatic logic [BYTE_W-1:0] status_byte(
        input logic       por,
        input logic       lock,
        input logic [2:0] adc
    );
        return {por, lock, 3'b000, adc};
    endfunction

    function automatic logic is_test(input logic re, input logic rts);
        return !re && rts;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import synth_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              frame_start,
    output logic              por_clr
);
    bus_state_e        st;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic              is_addr, rd, m_ack, read_seen;

    always_ff @(posedge clk) begin
        wr_stb      <= 1'b0;
        frame_start <= 1'b0;
        por_clr     <= 1'b0;
        if (rst) begin
            st        <= BS_IDLE;
            cnt       <= '0;
            sh        <= '0;
            is_addr   <= 1'b0;
            rd        <= 1'b0;
            m_ack     <= 1'b0;
            read_seen <= 1'b0;
            sda_oe    <= 1'b0;
            wr_byte   <= '0;
        end else if (stop_det) begin
            st        <= BS_IDLE;
            sda_oe    <= 1'b0;
            por_clr   <= read_seen;
            read_seen <= 1'b0;
        end else if (start_det) begin
            st        <= BS_RX;
            cnt       <= '0;
            is_addr   <= 1'b1;
            sda_oe    <= 1'b0;
            read_seen <= 1'b0;
        end else begin
            case (st)
                BS_RX: begin
                    if (scl_rise && cnt != 4'd8) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt <= '0;
                        if (is_addr) begin
                            is_addr <= 1'b0;
                            if (sh[7:1] == {DEV_ID, addr_sel}) begin
                                rd          <= sh[0];
                                sda_oe      <= 1'b1;
                                st          <= BS_ACK;
                                frame_start <= ~sh[0];
                            end else begin
                                st <= BS_IDLE;
                            end
                        end else begin
                            wr_stb  <= 1'b1;
                            wr_byte <= sh;
                            sda_oe  <= 1'b1;
                            st      <= BS_ACK;
                        end
                    end
                end
                BS_ACK: begin
                    if (scl_fall) begin
                        if (rd) begin
                            sh        <= status;
                            sda_oe    <= ~status[7];
                            cnt       <= '0;
                            read_seen <= 1'b1;
                            st        <= BS_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= BS_RX;
                        end
                    end
                end
                BS_TX: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            st     <= BS_RACK;
                        end else begin
                            sda_oe <= ~sh[6];
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                BS_RACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            sh     <= status;
                            sda_oe <= ~status[7];
                            cnt    <= '0;
                            st     <= BS_TX;
                        end else begin
                            st <= BS_IDLE;
                        end
                    end
                end
                default: st <= BS_IDLE;
            endcase
        end
    end

    AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe) else $error("sda held after STOP"); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == BS_IDLE) |-> !sda_oe) else $error("sda driven while idle"); // R9

endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
    import synth_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              por_event,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              frame_start,
    input  logic              stop_det,
    input  logic              por_clr,
    output logic [DIV_W-1:0]  active,
    output ctl_regs_t         ctl,
    output logic              hiz,
    output logic              por_flag
);
    byte_role_e       role;
    logic [DIV_W-1:0] staged, nxt_staged;
    logic             got_hi, got_lo, got_aux;
    logic             nxt_hi, nxt_lo, nxt_aux, full_set, commit;

    always_comb begin
        nxt_staged = staged;
        nxt_hi     = got_hi;
        nxt_lo     = got_lo;
        nxt_aux    = got_aux;
        if (wr_stb) begin
            case (role)
                ROLE_LEAD: begin
                    if (wr_byte[7]) begin
                        nxt_staged[16:15] = wr_byte[6:5];
                        nxt_aux           = 1'b1;
                    end else begin
                        nxt_staged[14:8] = wr_byte[6:0];
                        nxt_hi           = 1'b1;
                    end
                end
                ROLE_LOW: begin
                    nxt_staged[7:0] = wr_byte;
                    nxt_lo          = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign full_set = nxt_hi & nxt_lo & nxt_aux;
    assign commit   = full_set | (stop_det & (got_hi | got_lo | got_aux));

    always_ff @(posedge clk) begin
        if (rst || por_event) begin
            role     <= ROLE_LEAD;
            active   <= '0;
            staged   <= '0;
            got_hi   <= 1'b0;
            got_lo   <= 1'b0;
            got_aux  <= 1'b0;
            ctl      <= CTL_RESET;
            hiz      <= 1'b1;
            por_flag <= 1'b1;
        end else begin
            if (por_clr) por_flag <= 1'b0;
            if (frame_start) role <= ROLE_LEAD;
            staged <= nxt_staged;
            if (commit) begin
                active  <= nxt_staged;
                got_hi  <= 1'b0;
                got_lo  <= 1'b0;
                got_aux <= 1'b0;
            end else begin
                got_hi  <= nxt_hi;
                got_lo  <= nxt_lo;
                got_aux <= nxt_aux;
            end
            if (wr_stb) begin
                case (role)
                    ROLE_LEAD: begin
                        role <= wr_byte[7] ? ROLE_CTRL : ROLE_LOW;
                        if (wr_byte[7]) begin
                            ctl.pe       <= wr_byte[4];
                            ctl.ref_code <= wr_byte[3:0];
                        end
                    end
                    ROLE_LOW: role <= ROLE_LEAD;
                    ROLE_CTRL: begin
                        role    <= ROLE_LEAD;
                        hiz     <= 1'b0;
                        ctl.cp  <= wr_byte[7:6];
                        ctl.re  <= wr_byte[5];
                        ctl.rts <= wr_byte[4];
                        if (is_test(wr_byte[5], wr_byte[4])) begin
                            ctl.tst     <= wr_byte[2:0];
                            ctl.port[3] <= wr_byte[3];
                        end else begin
                            ctl.port <= wr_byte[3:0];
                        end
                    end
                    default: role <= ROLE_LEAD;
                endcase
            end
        end
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && !stop_det && !por_event) |=> $stable(active))
        else $error("ratio moved without a byte or STOP"); // R3

    AST_TEST_KEEPS_PORTS: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && role == ROLE_CTRL && !wr_byte[5] && wr_byte[4] && !por_event)
        |=> (ctl.port[2:0] == $past(ctl.port[2:0])))
        else $error("test byte altered low ports"); // R7

    AST_POR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        por_event |=> (active == '0 && hiz && por_flag))
        else $error("power-on event did not clear state"); // R10

endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c
    import synth_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [1:0]       addr_sel,
    input  logic             lock_in,
    input  logic [2:0]       adc_code,
    input  logic             por_event,
    output logic [DIV_W-1:0] div_ratio,
    output logic             presc_en,
    output logic [3:0]       ref_code,
    output logic [1:0]       cp_cur,
    output logic             refout_en,
    output logic             refout_sel,
    output logic [3:0]       port_drv,
    output logic             port_hiz,
    output logic             test_active,
    output logic [2:0]       test_code
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb, frame_start, por_clr, hiz, por_flag;
    logic [BYTE_W-1:0] wr_byte, status;
    ctl_regs_t         ctl;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign status = status_byte(por_flag, lock_in, adc_code);

    i2c_byte_engine u_eng (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .status(status), .sda_oe(sda_oe),
        .wr_stb(wr_stb), .wr_byte(wr_byte), .frame_start(frame_start),
        .por_clr(por_clr)
    );

    synth_reg_bank u_regs (
        .clk(clk), .rst(rst), .por_event(por_event), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .frame_start(frame_start), .stop_det(stop_det),
        .por_clr(por_clr), .active(div_ratio), .ctl(ctl), .hiz(hiz),
        .por_flag(por_flag)
    );

    assign presc_en    = ctl.pe;
    assign ref_code    = ctl.ref_code;
    assign cp_cur      = ctl.cp;
    assign refout_en   = ctl.re;
    assign refout_sel  = ctl.rts;
    assign port_hiz    = hiz;
    assign port_drv    = hiz ? 4'h0 : ctl.port;
    assign test_active = is_test(ctl.re, ctl.rts);
    assign test_code   = test_active ? ctl.tst : 3'b000;

endmodule

// File: tb/synth_ctl_i2c_test.sv
`timescale 1ns/1ps
module synth_ctl_i2c_test;
    localparam int Q = 8;
    localparam logic [1:0] MY_SEL = 2'b01;
    // {order, ratio[16:0], pe, ref[3:0], port byte}
    localparam logic [30:0] VEC [4] = '{
        {1'b0, 17'h1ABCD, 1'b1, 4'h3, 8'hB5},
        {1'b1, 17'h00F0F, 1'b0, 4'hA, 8'h6A},
        {1'b0, 17'h1FFFF, 1'b1, 4'hF, 8'h00},
        {1'b1, 17'h00001, 1'b0, 4'h0, 8'hFF}
    };

    logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
    logic lock_in = 1'b1, por_event = 1'b0;
    logic [2:0] adc_code = 3'd5;
    logic sda_oe, sda_bus, presc_en, refout_en, refout_sel, port_hiz, test_active;
    logic [16:0] div_ratio;
    logic [3:0] ref_code, port_drv;
    logic [1:0] cp_cur;
    logic [2:0] test_code;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    synth_ctl_i2c uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
        .addr_sel(MY_SEL), .lock_in(lock_in), .adc_code(adc_code),
        .por_event(por_event), .div_ratio(div_ratio), .presc_en(presc_en),
        .ref_code(ref_code), .cp_cur(cp_cur), .refout_en(refout_en),
        .refout_sel(refout_sel), .port_drv(port_drv), .port_hiz(port_hiz),
        .test_active(test_active), .test_code(test_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq(); hq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); b = sda_bus; hq(); scl_m = 1'b0; hq();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack_n);
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~mack);
    endtask

    task automatic wseq(input string tag, input logic [7:0] v);
        logic a;
        wbyte(v, a);
        chk(tag, {31'd0, a}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic        a;
        logic [7:0]  rb;
        logic [7:0]  aw, ar;
        aw = {5'b11000, MY_SEL, 1'b0};
        ar = {5'b11000, MY_SEL, 1'b1};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R10 reset state
        chk("R10 reset ratio", {15'd0, div_ratio}, 32'd0);
        chk("R10 reset ctl", {presc_en, ref_code, cp_cur, refout_en, refout_sel},
            {1'b0, 4'h0, 2'b00, 1'b1, 1'b1});
        chk("R10 reset ports", {port_hiz, port_drv, test_active, sda_oe}, {1'b1, 4'h0, 1'b0, 1'b0});

        // vector walk: R1 R2 R3 R6
        for (int v = 0; v < 4; v++) begin
            logic [16:0] f;
            logic [7:0]  b2, b3, b4, b5;
            f  = VEC[v][29:13];
            b2 = {1'b0, f[14:8]};
            b3 = f[7:0];
            b4 = {1'b1, f[16:15], VEC[v][12], VEC[v][11:8]};
            b5 = VEC[v][7:0];
            bus_start();
            wseq("R1 address ack", aw);
            if (VEC[v][30] == 1'b0) begin
                wseq("R1 data ack", b2); wseq("R1 data ack", b3);
                wseq("R1 data ack", b4); wseq("R1 data ack", b5);
            end else begin
                wseq("R1 data ack", b4); wseq("R1 data ack", b5);
                wseq("R1 data ack", b2); wseq("R1 data ack", b3);
            end
            chk("R3 ratio after 17 bits, before STOP", {15'd0, div_ratio}, {15'd0, f});
            chk("R2 control fields", {27'd0, presc_en, ref_code}, {27'd0, VEC[v][12], VEC[v][11:8]});
            chk("R6 port byte fields", {23'd0, cp_cur, refout_en, refout_sel, port_drv, port_hiz},
                {23'd0, b5[7:6], b5[5], b5[4], b5[3:0], 1'b0});
            bus_stop();
        end

        // R3: repeated frequency pair alone holds the ratio; R4 STOP commits
        bus_start();
        wseq("R1 ack", aw);
        wseq("R2 ack", 8'h12); wseq("R2 ack", 8'h34);
        wseq("R2 ack", 8'h56); wseq("R2 ack", 8'h78);
        chk("R3 pair-only no change", {15'd0, div_ratio}, 32'h00001);
        bus_stop();
        chk("R4 STOP commits pair", {15'd0, div_ratio}, 32'h05678);

        // R4: high byte then STOP merges with held low byte
        bus_start(); wseq("R1 ack", aw); wseq("R4 ack", 8'h2A); bus_stop();
        chk("R4 single byte STOP", {15'd0, div_ratio}, 32'h02A78);

        // R2/R4: control byte then STOP
        bus_start(); wseq("R1 ack", aw); wseq("R2 ack", 8'hE5); bus_stop();
        chk("R4 control byte STOP ratio", {15'd0, div_ratio}, 32'h1AA78);
        chk("R2 control byte fields", {27'd0, presc_en, ref_code}, {27'd0, 1'b0, 4'h5});

        // R5: STOP inside a byte
        bus_start(); wseq("R1 ack", aw); wseq("R5 ack", 8'h11);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        chk("R5 partial byte discarded", {15'd0, div_ratio}, 32'h19178);

        // R1: wrong address is not acknowledged and frame ignored
        bus_start();
        wbyte({5'b11000, 2'b10, 1'b0}, a);
        chk("R1 foreign address nack", {31'd0, a}, 32'd1);
        wbyte(8'h00, a);
        chk("R1 foreign data nack", {31'd0, a}, 32'd1);
        bus_stop();
        chk("R1 foreign frame ignored", {15'd0, div_ratio}, 32'h19178);

        // R7: test mode keeps low ports
        bus_start(); wseq("R1 ack", aw); wseq("R7 ack", 8'hE5); wseq("R7 ack", 8'h26); bus_stop();
        chk("R7 normal ports first", {28'd0, port_drv}, 32'h6);
        bus_start(); wseq("R1 ack", aw); wseq("R7 ack", 8'hE5); wseq("R7 ack", 8'hDB); bus_stop();
        chk("R7 test mode", {24'd0, port_drv, test_active, test_code},
            {24'd0, 4'hE, 1'b1, 3'd3});
        chk("R7 cp in test byte", {30'd0, cp_cur}, 32'd3);

        // R8 / R9: reads
        bus_start(); wseq("R1 read address ack", ar);
        rbyte(1'b1, rb);
        chk("R8 status first", {24'd0, rb}, 32'hC5);
        rbyte(1'b0, rb);
        chk("R8 status repeat", {24'd0, rb}, 32'hC5);
        rbyte(1'b0, rb);
        chk("R9 released after nack", {24'd0, rb}, 32'hFF);
        bus_stop();
        bus_start(); wseq("R1 read address ack", ar);
        rbyte(1'b0, rb);
        bus_stop();
        chk("R8 power-on flag cleared", {24'd0, rb}, 32'h45);

        // R10: power-on event
        @(negedge clk); por_event = 1'b1; @(negedge clk); por_event = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 por ratio", {15'd0, div_ratio}, 32'd0);
        chk("R10 por outputs", {presc_en, ref_code, cp_cur, refout_en, refout_sel,
            port_hiz, port_drv, test_active}, {1'b0, 4'h0, 2'b00, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0});
        bus_start(); wseq("R1 read address ack", ar);
        rbyte(1'b0, rb);
        bus_stop();
        chk("R10 por flag set", {24'd0, rb}, 32'hC5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule